// File: doc/BRIEF.md
# DMA Channel Sequencer

This block is the register set and transfer sequencer for a single DMA channel. Software loads a source address, a destination address, a count of transfer units, a command word and a status/control word through a simple register port. Once the channel is armed, it asks an external arbiter for service. For every unit the arbiter grants, it steps the addresses by the unit size and counts down one unit.

When the last unit is granted, the channel stops asking for service and sets its completion flags. It raises its interrupt bit if the command word enables that interrupt. Software acknowledges completion by clearing the enable and done bits in the status word. Moving the data and following descriptor chains are handled elsewhere. This block only supplies addresses and bookkeeping to the data mover.

Top module: `dma_chan_engine`

## Requirements
- R1: After a synchronous reset, every register reads zero and `xfer_req` and `irq` are low.
- R2: Registers sit at these window offsets: source 0x00, destination 0x04, unit count 0x08, request type 0x0C, status 0x10, command 0x14, descriptor address 0x18. `reg_rdata` is registered. It shows the register at `reg_addr` as it stood before the same clock edge. The status register keeps only bits 0, 1, 2, 3, 4, 6 and 31, so writing 0xFFFFFFFE reads back 0x8000005E.
- R3: Command bits 10:8 give the unit size: code 0 is 4 bytes, 1 is 1 byte, 2 is 2 bytes, 3 is 16 bytes, 4 is 32 bytes, and any other code is 1 byte. On each granted unit the source address grows by the unit size only if command bit 23 is set, and the destination address only if bit 22 is set. Otherwise the address stays fixed.
- R4: `xfer_req` is high in a cycle exactly when the current registers hold status bit 0 (enable) set, status bit 31 (no-descriptor mode) set, status bit 2 (halt) clear, and a nonzero unit count.
- R5: A grant is a cycle with both `xfer_req` and `xfer_gnt` high. Each grant lowers the count by one. `xfer_gnt` while `xfer_req` is low changes nothing.
- R6: A grant that finds a count of 1 leaves the count at 0. In the same edge it sets status bit 3 (done) and bit 1 (count terminated), and `xfer_req` is low from the next cycle.
- R7: `irq` is registered and is high exactly when status bit 3 and command bit 1 (done interrupt enable) are both set.
- R8: Writing the status register with bits 0 and 3 clear drops `irq` and `xfer_req` from the next cycle.
- R9: A write to the count register while status bit 0 is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW (5) | Register offset within the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| xfer_req | output | 1 | Request for one transfer unit |
| xfer_gnt | input | 1 | Arbiter grant for the current unit |
| src_addr | output | AW (32) | Current source address |
| dst_addr | output | AW (32) | Current destination address |
| irq | output | 1 | Channel completion interrupt |

## Verification
The bench targets several corner cases:
- Every size code, including the undefined ones. A wrong size decode would land the source address at the wrong byte after two units.
- A count write while the channel is armed. A design that accepted it would restart a finished channel or corrupt the residue that software reads back.
- Grants that arrive while no request is up. A design that did not qualify the grant would drift its addresses.
- Halt and no-descriptor gating. A design that ignored either bit would request transfers it must not.
- Completion with the interrupt disabled, and the acknowledge write. A wrong design would leave the interrupt stuck, or raise it for a channel whose interrupt is off.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam logic [4:0] OFS_SRC  = 5'h00;
  localparam logic [4:0] OFS_DST  = 5'h04;
  localparam logic [4:0] OFS_CNT  = 5'h08;
  localparam logic [4:0] OFS_RTYP = 5'h0C;
  localparam logic [4:0] OFS_STAT = 5'h10;
  localparam logic [4:0] OFS_CMD  = 5'h14;
  localparam logic [4:0] OFS_DESC = 5'h18;

  localparam int ST_EN     = 0;
  localparam int ST_TERM   = 1;
  localparam int ST_HALT   = 2;
  localparam int ST_DONE   = 3;
  localparam int ST_NODESC = 31;
  localparam logic [31:0] ST_KEEP = 32'h8000_005F;

  localparam int CM_SINC  = 23;
  localparam int CM_DINC  = 22;
  localparam int CM_IRQEN = 1;
  localparam int CM_SZ_LO = 8;

  function automatic logic [5:0] unit_bytes(input logic [2:0] code);
    case (code)
      3'd0:    unit_bytes = 6'd4;
      3'd2:    unit_bytes = 6'd2;
      3'd3:    unit_bytes = 6'd16;
      3'd4:    unit_bytes = 6'd32;
      default: unit_bytes = 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/chan_addr_reg.sv
module chan_addr_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic [5:0]    step_bytes,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= q + AW'(step_bytes);
  end
endmodule

// File: rtl/chan_unit_cnt.sv
module chan_unit_cnt #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] q,
  output logic [CW-1:0] q_next,
  output logic          last
);
  always_comb begin
    q_next = q;
    if (load)     q_next = load_val;
    else if (dec) q_next = q - CW'(1);
  end

  assign last = (q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 24,
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           xfer_req,
  input  logic           xfer_gnt,
  output logic [AW-1:0]  src_addr,
  output logic [AW-1:0]  dst_addr,
  output logic           irq
);
  localparam int NADDR = 2;

  logic [31:0]   st_q, st_n, cmd_q, cmd_n, rtyp_q, desc_q, rd_mux;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_last, fire, run_n;
  logic          wr_src, wr_dst, wr_cnt, wr_st, wr_cmd, wr_rtyp, wr_desc;
  logic [5:0]    ubytes;

  logic [NADDR-1:0] a_load, a_step;
  logic [AW-1:0]    a_q [NADDR];

  assign wr_src  = reg_wr && (reg_addr == RAW'(OFS_SRC));
  assign wr_dst  = reg_wr && (reg_addr == RAW'(OFS_DST));
  assign wr_cnt  = reg_wr && (reg_addr == RAW'(OFS_CNT)) && !st_q[ST_EN];
  assign wr_st   = reg_wr && (reg_addr == RAW'(OFS_STAT));
  assign wr_cmd  = reg_wr && (reg_addr == RAW'(OFS_CMD));
  assign wr_rtyp = reg_wr && (reg_addr == RAW'(OFS_RTYP));
  assign wr_desc = reg_wr && (reg_addr == RAW'(OFS_DESC));

  assign fire   = xfer_req && xfer_gnt;
  assign ubytes = unit_bytes(cmd_q[CM_SZ_LO +: 3]);

  assign a_load[0] = wr_src;
  assign a_load[1] = wr_dst;
  assign a_step[0] = fire && cmd_q[CM_SINC];
  assign a_step[1] = fire && cmd_q[CM_DINC];

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    chan_addr_reg #(.AW(AW)) u_addr (
      .clk        (clk),
      .rst        (rst),
      .load       (a_load[g]),
      .load_val   (reg_wdata[AW-1:0]),
      .step       (a_step[g]),
      .step_bytes (ubytes),
      .q          (a_q[g])
    );
  end

  assign src_addr = a_q[0];
  assign dst_addr = a_q[1];

  chan_unit_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_cnt),
    .load_val (reg_wdata[CW-1:0]),
    .dec      (fire),
    .q        (cnt_q),
    .q_next   (cnt_n),
    .last     (cnt_last)
  );

  always_comb begin
    st_n = st_q;
    if (wr_st) st_n = reg_wdata & ST_KEEP;
    if (fire && cnt_last) begin
      st_n[ST_DONE] = 1'b1;
      st_n[ST_TERM] = 1'b1;
    end
  end

  assign cmd_n = wr_cmd ? reg_wdata : cmd_q;
  assign run_n = st_n[ST_EN] && st_n[ST_NODESC] && !st_n[ST_HALT] && (cnt_n != '0);

  always_comb begin
    case (reg_addr)
      RAW'(OFS_SRC):  rd_mux = 32'(a_q[0]);
      RAW'(OFS_DST):  rd_mux = 32'(a_q[1]);
      RAW'(OFS_CNT):  rd_mux = 32'(cnt_q);
      RAW'(OFS_RTYP): rd_mux = rtyp_q;
      RAW'(OFS_STAT): rd_mux = st_q;
      RAW'(OFS_CMD):  rd_mux = cmd_q;
      RAW'(OFS_DESC): rd_mux = desc_q;
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= '0;
      cmd_q     <= '0;
      rtyp_q    <= '0;
      desc_q    <= '0;
      xfer_req  <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      st_q      <= st_n;
      cmd_q     <= cmd_n;
      if (wr_rtyp) rtyp_q <= reg_wdata;
      if (wr_desc) desc_q <= reg_wdata;
      xfer_req  <= run_n;
      irq       <= st_n[ST_DONE] && cmd_n[CM_IRQEN];
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int AW  = 32,
  parameter int CW  = 24,
  parameter int RAW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic [RAW-1:0] reg_addr,
  input logic           xfer_req,
  input logic           xfer_gnt,
  input logic [AW-1:0]  src_addr,
  input logic [AW-1:0]  dst_addr,
  input logic           irq,
  input logic [31:0]    st_q,
  input logic [CW-1:0]  cnt_q
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!xfer_req && !irq));

  a_r4_req_gated: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> (st_q[0] && st_q[31] && !st_q[2] && cnt_q != '0));

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!xfer_req && !reg_wr) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(cnt_q)));

  a_r6_last_stop: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_gnt && cnt_q == CW'(1) && !reg_wr)
      |=> (!xfer_req && st_q[3] && st_q[1] && cnt_q == '0));

  a_r7_irq_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> st_q[3]);

  a_r9_cnt_locked: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RAW'(5'h08) && st_q[0] && !(xfer_req && xfer_gnt))
      |=> $stable(cnt_q));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .CW(CW), .RAW(RAW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .xfer_req (xfer_req),
  .xfer_gnt (xfer_gnt),
  .src_addr (src_addr),
  .dst_addr (dst_addr),
  .irq      (irq),
  .st_q     (st_q),
  .cnt_q    (cnt_q)
);

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_req, xfer_gnt = 1'b0, irq;
  logic [31:0] src_addr, dst_addr;

  int nchk = 0, nfail = 0, cyc = 0;
  bit started = 1'b0;

  logic [31:0] m_src = '0, m_dst = '0, m_st = '0, m_cmd = '0, m_rt = '0, m_desc = '0, m_rd = '0;
  logic [23:0] m_cnt = '0;
  logic        m_req = 1'b0, m_irq = 1'b0;

  always #5 clk = ~clk;

  dma_chan_engine uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .xfer_gnt(xfer_gnt), .src_addr(src_addr), .dst_addr(dst_addr), .irq(irq)
  );

  function automatic int size_of(input int code);
    case (code)
      0: return 4;
      1: return 1;
      2: return 2;
      3: return 16;
      4: return 32;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // behavioural reference, stepped on every rising edge
  always @(posedge clk) begin : model
    logic        fire;
    int          unit;
    logic [31:0] ost;
    if (rst) begin
      m_src = 0; m_dst = 0; m_cnt = 0; m_st = 0; m_cmd = 0;
      m_rt = 0; m_desc = 0; m_rd = 0; m_req = 0; m_irq = 0;
    end else begin
      case (reg_addr)
        5'h00: m_rd = m_src;
        5'h04: m_rd = m_dst;
        5'h08: m_rd = {8'h0, m_cnt};
        5'h0C: m_rd = m_rt;
        5'h10: m_rd = m_st;
        5'h14: m_rd = m_cmd;
        5'h18: m_rd = m_desc;
        default: m_rd = 0;
      endcase
      fire = m_req && xfer_gnt;
      unit = size_of(int'(m_cmd[10:8]));
      ost  = m_st;
      if (reg_wr && reg_addr == 5'h00) m_src = reg_wdata;
      else if (fire && m_cmd[23]) m_src = m_src + unit;
      if (reg_wr && reg_addr == 5'h04) m_dst = reg_wdata;
      else if (fire && m_cmd[22]) m_dst = m_dst + unit;
      if (reg_wr && reg_addr == 5'h10) m_st = reg_wdata & 32'h8000_005F;
      if (fire && m_cnt == 1) m_st = m_st | 32'h0000_000A;
      if (reg_wr && reg_addr == 5'h08 && !ost[0]) m_cnt = reg_wdata[23:0];
      else if (fire) m_cnt = m_cnt - 1;
      if (reg_wr && reg_addr == 5'h14) m_cmd = reg_wdata;
      if (reg_wr && reg_addr == 5'h0C) m_rt = reg_wdata;
      if (reg_wr && reg_addr == 5'h18) m_desc = reg_wdata;
      m_req = m_st[0] && m_st[31] && !m_st[2] && (m_cnt != 0);
      m_irq = m_st[3] && m_cmd[1];
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R4 request vs model", {31'h0, xfer_req}, {31'h0, m_req});
      chk("R7 irq vs model", {31'h0, irq}, {31'h0, m_irq});
      chk("R3 source vs model", src_addr, m_src);
      chk("R3 destination vs model", dst_addr, m_dst);
      chk("R2 read data vs model", reg_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      report();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  logic [31:0] v;

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4), v);
      chk("R1 register zero after reset", v, 32'h0);
    end
    chk("R1 req low after reset", {31'h0, xfer_req}, 32'h0);
    chk("R1 irq low after reset", {31'h0, irq}, 32'h0);

    // R2: status keeps only defined bits
    wr(5'h10, 32'hFFFF_FFFE);
    rd(5'h10, v);
    chk("R2 status mask", v, 32'h8000_005E);
    wr(5'h0C, 32'h0000_0015);
    wr(5'h18, 32'hABCD_0040);
    rd(5'h0C, v); chk("R2 request type", v, 32'h15);
    rd(5'h18, v); chk("R2 descriptor address", v, 32'hABCD_0040);

    // main run: 3 units of 4 bytes, both increment, irq enabled
    wr(5'h10, 32'h8000_0000);
    wr(5'h00, 32'h0000_1000);
    wr(5'h04, 32'h0000_2000);
    wr(5'h08, 32'd3);
    wr(5'h14, 32'h00C0_0002);
    wr(5'h10, 32'h8000_0001);
    chk("R4 request once armed", {31'h0, xfer_req}, 32'h1);
    xfer_gnt = 1'b1;
    tick(5);
    xfer_gnt = 1'b0;
    tick(1);
    rd(5'h08, v); chk("R5 count reaches zero", v, 32'h0);
    rd(5'h10, v); chk("R6 done and terminate set", v, 32'h8000_000B);
    chk("R3 source advanced 12", src_addr, 32'h0000_100C);
    chk("R3 destination advanced 12", dst_addr, 32'h0000_200C);
    chk("R6 request dropped", {31'h0, xfer_req}, 32'h0);
    chk("R7 irq raised", {31'h0, irq}, 32'h1);

    // R9: count write while enabled
    wr(5'h08, 32'd5);
    rd(5'h08, v); chk("R9 count write ignored", v, 32'h0);
    chk("R9 no request after ignored write", {31'h0, xfer_req}, 32'h0);

    // R8: acknowledge
    wr(5'h10, 32'h8000_0000);
    chk("R8 irq cleared", {31'h0, irq}, 32'h0);
    chk("R8 request low", {31'h0, xfer_req}, 32'h0);

    // R5: grant without request
    xfer_gnt = 1'b1;
    tick(3);
    xfer_gnt = 1'b0;
    chk("R5 stray grant source", src_addr, 32'h0000_100C);
    chk("R5 stray grant destination", dst_addr, 32'h0000_200C);

    // R3: every size code, source increments, destination fixed
    for (int code = 0; code < 8; code++) begin
      wr(5'h10, 32'h8000_0000);
      wr(5'h00, 32'h0000_4000);
      wr(5'h04, 32'h0000_5000);
      wr(5'h08, 32'd2);
      wr(5'h14, 32'h0080_0000 | (32'(code) << 8));
      wr(5'h10, 32'h8000_0001);
      xfer_gnt = 1'b1;
      tick(4);
      xfer_gnt = 1'b0;
      chk("R3 size code step", src_addr, 32'h0000_4000 + 32'(2 * size_of(code)));
      chk("R3 fixed destination", dst_addr, 32'h0000_5000);
      chk("R7 no irq when disabled", {31'h0, irq}, 32'h0);
    end

    // R4: halt and no-descriptor gating
    wr(5'h10, 32'h8000_0000);
    wr(5'h08, 32'd2);
    wr(5'h10, 32'h8000_0005);
    tick(2);
    chk("R4 halted no request", {31'h0, xfer_req}, 32'h0);
    wr(5'h10, 32'h0000_0001);
    tick(1);
    chk("R4 no-descriptor clear no request", {31'h0, xfer_req}, 32'h0);
    wr(5'h10, 32'h8000_0001);
    chk("R4 request when allowed", {31'h0, xfer_req}, 32'h1);

    // intermittent grants, checked against the model every cycle
    wr(5'h10, 32'h8000_0000);
    wr(5'h08, 32'd4);
    wr(5'h14, 32'h0040_0302);
    wr(5'h10, 32'h8000_0001);
    for (int i = 0; i < 12; i++) begin
      xfer_gnt = i[0];
      tick(1);
    end
    xfer_gnt = 1'b0;
    tick(2);
    rd(5'h08, v); chk("R6 count zero after pattern", v, 32'h0);
    chk("R7 irq after patterned run", {31'h0, irq}, 32'h1);

    report();
  end
endmodule